// File: doc/BRIEF.md
# Ping-Pong One-Shot DMA Channel

This block is a single receive DMA channel that moves bytes from a peripheral into memory. It holds two full descriptor sets. Each set has a buffer address, a byte count and a command word. At any moment one set is the active set, and only that set is executed.

While the active set runs, software fills the other set. When the active count runs out, the channel marks that set finished and releases it, then turns straight to the other set. If the other set is armed, transfers continue with no dead cycle.

Each finished set leaves a sticky completion flag. The interrupt line is the OR of those flags. If the channel flips to a set that is not armed, it stops and raises a starvation status bit. Software clears the flags by writing ones to the control word.

Top module: `pp_dma_channel`

## Requirements
- R1: Register offsets (byte address on `regAddr`):
  - Set s (s = 0 or 1) starts at 0x10·s. Its address register is at +0x0, its byte count is at +0x4 (low 16 bits) and its command is at +0x8.
  - In the command word, bit 0 is the armed bit.
  - The control word is at 0x20. Its bits are: 0 = done of set 0, 1 = done of set 1, 2 = starved, 3 = active set index (read only), 4 = busy (read only). Busy means the active set is armed.
  - All other read bits are zero.
- R2: Only the active set is ever executed. The active set is set 0 after reset. A set whose armed bit is clear moves no data.
- R3: A byte is taken from the peripheral when `perValid` and `perReady` are both high. `perReady` is high only while the active set is armed, its count is nonzero and no memory write is pending. In the next cycle one memory write is presented:
  - address = the set's current address;
  - `memBe` = one-hot of address bits [1:0];
  - the byte is copied onto all four lanes of `memWdata`.
  The write is held stable until `memReady`.
- R4: Each accepted memory write adds one to the active set's address and subtracts one from its count, on the same edge.
- R5: On the edge where the count reaches zero, three things happen together: that set's armed bit clears, its done flag sets, and the active index flips. If the new active set is armed, `perReady` may be high in the very next cycle.
- R6: If the other set was not armed when the flip happened, the starved bit sets and the channel stays idle on that set until the set is armed.
- R7: An armed active set with a count of zero completes on the next edge and issues no memory request.
- R8: Writes to the address, count or command of the active set are ignored while that set is armed.
- R9: `irq` is high exactly when either done flag is set. Writing 1 to a bit of the control word clears that flag. If hardware sets a flag on the same edge, the set wins.
- R10: After reset, all registers read zero, and `irq`, `perReady` and `memValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| memAddr | output | 32 | Memory write byte address |
| memWdata | output | 32 | Memory write data, byte replicated |
| memBe | output | 4 | Memory byte strobe |
| memValid | output | 1 | Memory write request |
| memReady | input | 1 | Memory accepts the request |
| perData | input | 8 | Peripheral byte |
| perValid | input | 1 | Peripheral byte available |
| perReady | output | 1 | Channel takes the byte |
| irq | output | 1 | Completion interrupt |

## Verification
Timing of each result:
- A peripheral handshake on edge k raises `memValid` right after edge k.
- A memory acceptance on edge k updates the address, the count, the done flags, the active index and `irq` right after edge k.
- A register write sampled on edge k is visible on `regRdata` after that edge.

The bench drives inputs 1 ns after each rising edge. It advances a behavioural model on the same rising edge as the design. It compares every output and the current read word at the falling edge, so each result is checked in the first cycle it is due. Explicit end-of-scenario reads then confirm the final address, count and control values computed by hand from the requirements.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic capture;  // peripheral byte accepted this edge
    logic step;     // memory write accepted this edge
    logic finish;   // active set completes this edge
  } dmaStrobes_t;

  localparam int unsigned FIELD_ADDR = 0;
  localparam int unsigned FIELD_LEN  = 1;
  localparam int unsigned FIELD_CMD  = 2;
endpackage

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
  import pp_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        activeArmed,
  input  logic        lenZero,
  input  logic        lenOne,
  input  logic        perValid,
  input  logic        memReady,
  output logic        perReady,
  output logic        memValid,
  output dmaStrobes_t strobes
);
  logic pending;

  always_comb begin
    perReady        = activeArmed && !lenZero && !pending;
    strobes.capture = perReady && perValid;
    strobes.step    = pending && memReady;
    strobes.finish  = activeArmed &&
                      ((lenZero && !pending) || (strobes.step && lenOne));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pending <= 1'b0;
    else if (strobes.capture) pending <= 1'b1;
    else if (strobes.step)    pending <= 1'b0;
  end

  assign memValid = pending;

  // a pending write is held until the memory takes it
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    pending && !memReady |=> pending);
  // no new byte while a write is outstanding
  assert_no_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !perReady);
  // zero-length set never has a request in flight
  assert_zero_no_mem_R7: assert property (@(posedge clk) disable iff (!rstN)
    activeArmed && lenZero |-> !pending);
endmodule

// File: rtl/pp_dma_path.sv
module pp_dma_path
  import pp_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobes_t       strobes,
  input  logic              regWe,
  input  logic [5:2]        regWord,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [7:0]        perData,
  output logic              activeArmed,
  output logic              lenZero,
  output logic              lenOne,
  output logic [ADDR_W-1:0] curAddr,
  output logic [7:0]        holdByte,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);
  localparam int unsigned NSETS = 2;

  logic [NSETS-1:0][ADDR_W-1:0] addrV;
  logic [NSETS-1:0][LEN_W-1:0]  lenV;
  logic [NSETS-1:0]             armedV;
  logic [NSETS-1:0]             doneV;
  logic                         actSel;
  logic                         starve;
  logic [LEN_W-1:0]             curLen;

  logic       wrCtl, wrSet, wrLocked;
  logic [1:0] wrField;

  assign wrCtl    = regWord[5];
  assign wrSet    = regWord[4];
  assign wrField  = regWord[3:2];
  assign wrLocked = armedV[wrSet] && (actSel == wrSet);

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic [ADDR_W-1:0] addrQ;
    logic [LEN_W-1:0]  lenQ;
    logic              armedQ, doneQ;
    logic              isActive, swWrite;

    assign isActive = (actSel == 1'(s));
    assign swWrite  = regWe && !wrCtl && (wrSet == 1'(s)) && !wrLocked;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ  <= '0;
        lenQ   <= '0;
        armedQ <= 1'b0;
        doneQ  <= 1'b0;
      end else begin
        if (swWrite) begin
          case (wrField)
            2'(FIELD_ADDR): addrQ  <= regWdata[ADDR_W-1:0];
            2'(FIELD_LEN):  lenQ   <= regWdata[LEN_W-1:0];
            2'(FIELD_CMD):  armedQ <= regWdata[0];
            default: ;
          endcase
        end
        if (isActive && strobes.step) begin
          addrQ <= addrQ + 1'b1;
          lenQ  <= lenQ - 1'b1;
        end
        if (isActive && strobes.finish) armedQ <= 1'b0;
        if (regWe && wrCtl && regWdata[s]) doneQ <= 1'b0;
        if (isActive && strobes.finish) doneQ <= 1'b1;
      end
    end

    assign addrV[s]  = addrQ;
    assign lenV[s]   = lenQ;
    assign armedV[s] = armedQ;
    assign doneV[s]  = doneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel <= 1'b0;
      starve <= 1'b0;
    end else begin
      if (regWe && wrCtl && regWdata[2]) starve <= 1'b0;
      if (strobes.finish) begin
        actSel <= ~actSel;
        if (!armedV[~actSel]) starve <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdByte <= '0;
    else if (strobes.capture) holdByte <= perData;
  end

  assign activeArmed = armedV[actSel];
  assign curLen      = lenV[actSel];
  assign curAddr     = addrV[actSel];
  assign lenZero     = (curLen == '0);
  assign lenOne      = (curLen == LEN_W'(1));
  assign irq         = |doneV;

  always_comb begin
    regRdata = '0;
    if (wrCtl) begin
      regRdata[4:0] = {activeArmed, actSel, starve, doneV[1], doneV[0]};
    end else begin
      case (wrField)
        2'(FIELD_ADDR): regRdata = DATA_W'(addrV[wrSet]);
        2'(FIELD_LEN):  regRdata = DATA_W'(lenV[wrSet]);
        2'(FIELD_CMD):  regRdata = DATA_W'(armedV[wrSet]);
        default:        regRdata = '0;
      endcase
    end
  end

  assert_step_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step && !strobes.finish |=> curLen == $past(curLen) - 1'b1);
  assert_step_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step && !strobes.finish |=> curAddr == $past(curAddr) + 1'b1);
  assert_flip_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> actSel != $past(actSel));
  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> irq);
  assert_starve_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish && !armedV[~actSel] |=> starve && !activeArmed);
  assert_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    activeArmed && !strobes.step && !strobes.finish |=> $stable(curAddr) && activeArmed);
endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
  import pp_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [5:0]          regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W/8-1:0] memBe,
  output logic                memValid,
  input  logic                memReady,
  input  logic [7:0]          perData,
  input  logic                perValid,
  output logic                perReady,
  output logic                irq
);
  localparam int unsigned BYTES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(BYTES);

  dmaStrobes_t strobes;
  logic        activeArmed, lenZero, lenOne;
  logic [7:0]  holdByte;
  logic [1:0]  unusedLow;

  assign unusedLow = regAddr[1:0];

  pp_dma_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .activeArmed(activeArmed), .lenZero(lenZero),
    .lenOne(lenOne), .perValid(perValid), .memReady(memReady),
    .perReady(perReady), .memValid(memValid), .strobes(strobes)
  );

  pp_dma_path #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWe(regWe),
    .regWord(regAddr[5:2]), .regWdata(regWdata), .perData(perData),
    .activeArmed(activeArmed), .lenZero(lenZero), .lenOne(lenOne),
    .curAddr(memAddr), .holdByte(holdByte), .regRdata(regRdata), .irq(irq)
  );

  assign memBe    = BYTES'(1) << memAddr[LANE_W-1:0];
  assign memWdata = {BYTES{holdByte}};

  assert_be_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> $countones(memBe) == 1);
  assert_stable_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memWdata));
endmodule

// File: tb/test_pp_dma_channel.sv
`timescale 1ns/1ps
module test_pp_dma_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata, memAddr, memWdata;
  logic [3:0]  memBe;
  logic        memValid, perReady, irq;
  logic        memReady = 1'b0;
  logic [7:0]  perData = '0;
  logic        perValid = 1'b0;

  int  checks = 0;
  int  errors = 0;
  bit  enPer = 1'b0;
  bit  running = 1'b0;
  int  cyc = 0;

  always #2.5 clk = ~clk;

  pp_dma_channel i_pp_dma_channel (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .memValid(memValid),
    .memReady(memReady), .perData(perData), .perValid(perValid),
    .perReady(perReady), .irq(irq)
  );

  // behavioural reference
  logic [31:0] mAddr [2];
  logic [15:0] mLen  [2];
  bit          mArm  [2];
  bit          mDone [2];
  bit          mStarve, mAct, mPend;
  logic [7:0]  mByte;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mAddr[i] = 0; mLen[i] = 0; mArm[i] = 0; mDone[i] = 0;
      end
      mStarve = 0; mAct = 0; mPend = 0; mByte = 0;
    end else begin
      bit a, busy, rdy, acc, wr, fin, otherArm, s;
      a = mAct;
      busy = mArm[a];
      rdy = busy && (mLen[a] != 0) && !mPend;
      acc = rdy && perValid;
      wr  = mPend && memReady;
      fin = busy && (((mLen[a] == 0) && !mPend) || (wr && (mLen[a] == 1)));
      otherArm = mArm[!a];
      if (regWe) begin
        if (regAddr[5]) begin
          if (regWdata[0]) mDone[0] = 0;
          if (regWdata[1]) mDone[1] = 0;
          if (regWdata[2]) mStarve = 0;
        end else begin
          s = regAddr[4];
          if (!(s == a && busy)) begin
            case (regAddr[3:2])
              2'd0: mAddr[s] = regWdata;
              2'd1: mLen[s]  = regWdata[15:0];
              2'd2: mArm[s]  = regWdata[0];
              default: ;
            endcase
          end
        end
      end
      if (acc) begin mPend = 1; mByte = perData; end
      if (wr) begin mPend = 0; mAddr[a] = mAddr[a] + 1; mLen[a] = mLen[a] - 1; end
      if (fin) begin
        mArm[a] = 0; mDone[a] = 1; mAct = !a;
        if (!otherArm) mStarve = 1;
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [5:0] ad);
    if (ad[5]) return {27'd0, mArm[mAct], mAct, mStarve, mDone[1], mDone[0]};
    case (ad[3:2])
      2'd0: return mAddr[ad[4]];
      2'd1: return {16'd0, mLen[ad[4]]};
      2'd2: return {31'd0, mArm[ad[4]]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (running) begin
      chk("R3 perReady", 32'(perReady),
          32'(mArm[mAct] && mLen[mAct] != 0 && !mPend));
      chk("R3 memValid", 32'(memValid), 32'(mPend));
      chk("R9 irq", 32'(irq), 32'(mDone[0] | mDone[1]));
      chk("R1 regRdata", regRdata, modelRead(regAddr));
      if (mPend) begin
        chk("R4 memAddr", memAddr, mAddr[mAct]);
        chk("R3 memBe", 32'(memBe), 32'(4'b0001 << mAddr[mAct][1:0]));
        chk("R3 memWdata", memWdata, {4{mByte}});
      end
    end
  end

  // peripheral and memory stimulus pattern
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      perValid = enPer && (cyc % 3 != 1);
      perData  = 8'(cyc) ^ 8'h5A;
      memReady = (cyc % 4 != 2);
    end
  end

  task automatic regWrite(logic [5:0] ad, logic [31:0] d);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = ad; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic regCheck(logic [5:0] ad, logic [31:0] exp, string req);
    @(posedge clk); #1;
    regAddr = ad;
    @(negedge clk);
    chk(req, regRdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  // watchdog
  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq", 32'(irq), 0);
    chk("R10 perReady", 32'(perReady), 0);
    chk("R10 memValid", 32'(memValid), 0);
    running = 1'b1;
    regCheck(6'h20, 32'h0, "R10 control");
    regCheck(6'h14, 32'h0, "R10 set1 len");

    // back-to-back sets, then starvation
    regWrite(6'h00, 32'h1000_0001);
    regWrite(6'h04, 32'd5);
    regWrite(6'h08, 32'd1);
    regWrite(6'h10, 32'h2000_0002);
    regWrite(6'h14, 32'd3);
    regWrite(6'h18, 32'd1);
    regCheck(6'h20, 32'h10, "R2 busy on set0");
    enPer = 1'b1;
    idle(80);
    regCheck(6'h00, 32'h1000_0006, "R4 set0 final addr");
    regCheck(6'h04, 32'h0, "R4 set0 final len");
    regCheck(6'h10, 32'h2000_0005, "R5 set1 final addr");
    regCheck(6'h20, 32'h07, "R6 done both and starved");

    // clear flags; irq drops
    regWrite(6'h20, 32'h7);
    @(negedge clk);
    chk("R9 irq cleared", 32'(irq), 0);

    // writes to the armed active set are ignored
    regWrite(6'h00, 32'h3000_0000);
    regWrite(6'h04, 32'd4);
    regWrite(6'h08, 32'd1);
    regWrite(6'h04, 32'd100);
    regWrite(6'h00, 32'h5555_0000);
    idle(40);
    regCheck(6'h00, 32'h3000_0004, "R8 addr unchanged by locked write");
    regCheck(6'h04, 32'h0, "R8 len unchanged by locked write");
    regCheck(6'h20, 32'h0D, "R5 flipped to set1 with done0");

    // zero-length set on set1
    enPer = 1'b0;
    regWrite(6'h20, 32'h7);
    regWrite(6'h10, 32'h4000_0000);
    regWrite(6'h14, 32'd0);
    regWrite(6'h18, 32'd1);
    idle(3);
    regCheck(6'h20, 32'h06, "R7 zero length completes");
    regCheck(6'h10, 32'h4000_0000, "R7 no address movement");
    regCheck(6'h18, 32'h0, "R5 armed bit cleared");

    // set0 unarmed, active: nothing moves
    enPer = 1'b1;
    regWrite(6'h04, 32'd2);
    idle(10);
    regCheck(6'h04, 32'd2, "R2 unarmed set does not run");

    running = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule